// File: doc/BRIEF.md
# Audio Soft-Mute and Level Controller

This block sits in a stereo audio path and scales each pair of 16-bit signed samples by a shared gain. The gain does not jump when a new command arrives. It moves one step at a time, so muting, restoring and fading are heard as smooth ramps. A separate fixed 12 dB cut can be switched in on top of the ramped gain.

Commands arrive as 4-bit codes with a write strobe. The gain is an index from 0 (silence) to 128. Index 128 is unity and passes samples through bit for bit. Each index step lasts a fixed number of clock cycles, and that number shrinks as the disc speed factor grows. A full mute therefore takes a constant time per unit of disc speed. Samples enter with a strobe, and the scaled pair leaves one clock later with its own strobe.

Top module: `lvl_audio_ctrl`

## Requirements
- R1: After reset the gain index is 0, the attenuation flag is clear, the ramp target is 0 and `smp_valid_o` is low.
- R2: A sample pair accepted on `smp_valid_i` appears on the outputs one cycle later with `smp_valid_o` high for that single cycle. Each channel equals (sample × g) >>> 7, where g is the gain index held at the accepting edge, and both channels use the same g.
- R3: Code 4'h1 (mute) sets the target to 0. The gain then falls by one per step and never rises until the next command. Starting from unity it reaches 0 after exactly 128 steps.
- R4: Code 4'h2 (full scale) clears the attenuation flag and sets the target to 128. Once the gain reaches 128, output equals input exactly.
- R5: One step lasts STEP_BASE >> speed_i cycles, where speed_i is log2 of the speed factor (0 to 3). The step counter restarts on every accepted command, so the gain after k full step periods is the start value moved by k.
- R6: Code 4'h3 (attenuate) sets the attenuation flag without touching the target. From the next sample on, each output is shifted right arithmetically by 2 more bits (a 12 dB cut).
- R7: Code 4'b1xyz (fade) sets the target to {x,y,z,4'b0000}. The gain steps toward that target in either direction and stops there.
- R8: A command issued mid-ramp continues from the gain held at that moment. The gain never changes by more than one index per cycle.
- R9: Codes 4'h0 and 4'h4 to 4'h7 are ignored. They change neither the target nor the attenuation flag, and the ramp is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 4 | Command code |
| speed_i | input | 2 | log2 of the disc speed factor |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_l_i | input | 16 | Left sample, two's complement |
| smp_r_i | input | 16 | Right sample, two's complement |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_l_o | output | 16 | Scaled left sample |
| smp_r_o | output | 16 | Scaled right sample |

## Verification
The bench builds the block with STEP_BASE = 16. A step then lasts 16, 8, 4 or 2 cycles depending on speed_i, so complete 128-step ramps fit in a few thousand cycles at every speed setting used. Probes use ±12800 as the input, so each output is exactly ±100 times the gain index. This lets the bench read the gain index back through the normal sample path at chosen step counts, including ramp ends, reversals and mid-ramp command changes.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  localparam logic [3:0] CMD_MUTE = 4'h1;
  localparam logic [3:0] CMD_FULL = 4'h2;
  localparam logic [3:0] CMD_ATTN = 4'h3;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_MUTE,
    ACT_FULL,
    ACT_ATTN,
    ACT_FADE
  } act_e;

  function automatic act_e classify(input logic [3:0] code);
    if (code[3])              return ACT_FADE;
    else if (code == CMD_MUTE) return ACT_MUTE;
    else if (code == CMD_FULL) return ACT_FULL;
    else if (code == CMD_ATTN) return ACT_ATTN;
    else                       return ACT_NONE;
  endfunction

endpackage

// File: rtl/lvl_step_timer.sv
module lvl_step_timer #(
  parameter int STEP_BASE = 1024,
  parameter int SPEED_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               tick_o
);
  localparam int CNT_W = $clog2(STEP_BASE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(STEP_BASE) >> speed_i;
  assign tick_o = (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/lvl_gain_ctrl.sv
module lvl_gain_ctrl
  import lvl_pkg::*;
#(
  parameter int FRAC_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic [3:0]      cmd_i,
  input  logic            tick_i,
  output logic            accept_o,
  output logic [FRAC_W:0] gain_o,
  output logic [FRAC_W:0] target_o,
  output logic            attn_o
);
  localparam int GAIN_W = FRAC_W + 1;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  act_e act;
  logic [GAIN_W-1:0] gain_q, target_q, fade_lvl;
  logic attn_q;

  assign act      = cmd_we_i ? classify(cmd_i) : ACT_NONE;
  assign accept_o = (act != ACT_NONE);
  // fade level: 3 command bits are the top bits of the step index
  assign fade_lvl = {1'b0, cmd_i[2:0], {(FRAC_W-3){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      attn_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_MUTE: target_q <= '0;
        ACT_FULL: begin
          target_q <= UNITY;
          attn_q   <= 1'b0;
        end
        ACT_ATTN: attn_q   <= 1'b1;
        ACT_FADE: target_q <= fade_lvl;
        default: ;
      endcase
    end
  end

  // gain holds on the command edge, then walks one index per tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= '0;
    else if (!accept_o && tick_i) begin
      if (gain_q < target_q)      gain_q <= gain_q + GAIN_W'(1);
      else if (gain_q > target_q) gain_q <= gain_q - GAIN_W'(1);
    end
  end

  assign gain_o   = gain_q;
  assign target_o = target_q;
  assign attn_o   = attn_q;
endmodule

// File: rtl/lvl_scale.sv
module lvl_scale #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 7
) (
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic        [FRAC_W:0]   gain_i,
  input  logic                     attn_i,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int PROD_W = DATA_W + FRAC_W + 2;

  logic signed [PROD_W-1:0] prod, shifted;
  logic signed [FRAC_W+1:0] gain_s;

  assign gain_s  = {1'b0, gain_i};
  assign prod    = PROD_W'(smp_i) * PROD_W'(gain_s);
  assign shifted = attn_i ? (prod >>> (FRAC_W + 2)) : (prod >>> FRAC_W);
  assign smp_o   = shifted[DATA_W-1:0];
endmodule

// File: rtl/lvl_audio_ctrl.sv
module lvl_audio_ctrl #(
  parameter int DATA_W    = 16,
  parameter int FRAC_W    = 7,
  parameter int SPEED_W   = 2,
  parameter int STEP_BASE = 1024
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_we_i,
  input  logic [3:0]               cmd_i,
  input  logic [SPEED_W-1:0]       speed_i,
  input  logic                     smp_valid_i,
  input  logic signed [DATA_W-1:0] smp_l_i,
  input  logic signed [DATA_W-1:0] smp_r_i,
  output logic                     smp_valid_o,
  output logic signed [DATA_W-1:0] smp_l_o,
  output logic signed [DATA_W-1:0] smp_r_o
);
  localparam int GAIN_W = FRAC_W + 1;
  localparam int NUM_CH = 2;

  logic tick, accept, attn;
  logic [GAIN_W-1:0] gain, target;
  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_scl [NUM_CH];
  logic signed [DATA_W-1:0] ch_q   [NUM_CH];
  logic valid_q;

  lvl_step_timer #(.STEP_BASE(STEP_BASE), .SPEED_W(SPEED_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(accept),
    .speed_i(speed_i), .tick_o(tick)
  );

  lvl_gain_ctrl #(.FRAC_W(FRAC_W)) u_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .tick_i(tick), .accept_o(accept), .gain_o(gain), .target_o(target),
    .attn_o(attn)
  );

  assign ch_in[0] = smp_l_i;
  assign ch_in[1] = smp_r_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lvl_scale #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_scale (
      .smp_i(ch_in[c]), .gain_i(gain), .attn_i(attn), .smp_o(ch_scl[c])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ch_q[c] <= '0;
      else if (smp_valid_i) ch_q[c] <= ch_scl[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= smp_valid_i;
  end

  assign smp_valid_o = valid_q;
  assign smp_l_o     = ch_q[0];
  assign smp_r_o     = ch_q[1];
endmodule

// File: rtl/lvl_audio_ctrl_chk.sv
module lvl_audio_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmd_we_i,
  input logic [3:0]               cmd_i,
  input logic                     smp_valid_i,
  input logic signed [DATA_W-1:0] smp_l_i,
  input logic                     smp_valid_o,
  input logic signed [DATA_W-1:0] smp_l_o,
  input logic [GAIN_W-1:0]        gain,
  input logic [GAIN_W-1:0]        target,
  input logic                     attn
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

  logic bad_code;
  assign bad_code = cmd_we_i && !cmd_i[3] && (cmd_i == 4'h0 || cmd_i[2]);

  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> smp_valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !smp_valid_o); // R2
  AST_MUTE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target == '0 && !cmd_we_i) |=> gain <= $past(gain)); // R3
  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && gain == UNITY && !attn) |=> smp_l_o == $past(smp_l_i)); // R4
  AST_ATTN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && gain == UNITY && attn) |=> smp_l_o == ($past(smp_l_i) >>> 2)); // R6
  AST_GAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain != $past(gain)) |-> (gain == $past(gain) + GAIN_W'(1) ||
                               gain == $past(gain) - GAIN_W'(1))); // R8
  AST_GAIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain <= UNITY); // R7
  AST_BAD_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_code |=> ($stable(target) && $stable(attn))); // R9
endmodule

bind lvl_audio_ctrl lvl_audio_ctrl_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
  .smp_valid_i(smp_valid_i), .smp_l_i(smp_l_i), .smp_valid_o(smp_valid_o),
  .smp_l_o(smp_l_o), .gain(gain), .target(target), .attn(attn)
);

// File: tb/lvl_audio_ctrl_test.sv
module lvl_audio_ctrl_test;
  localparam int BASE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [3:0] cmd = '0;
  logic [1:0] speed = '0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_l = '0, smp_r = '0;
  logic smp_valid_o;
  logic signed [15:0] smp_l_o, smp_r_o;
  int cyc = 0, n_run = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lvl_audio_ctrl #(.STEP_BASE(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .speed_i(speed), .smp_valid_i(smp_valid), .smp_l_i(smp_l), .smp_r_i(smp_r),
    .smp_valid_o(smp_valid_o), .smp_l_o(smp_l_o), .smp_r_o(smp_r_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [3:0] c, output int e);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0; e = cyc;
  endtask

  // sample captured at edge t with gain g; input +/-12800 gives +/-100*g
  task automatic probe_at(input int t, input int g, input bit at, input string req);
    int el, er;
    while (cyc < t - 1) @(negedge clk);
    smp_valid = 1'b1; smp_l = 16'sd12800; smp_r = -16'sd12800;
    @(negedge clk); smp_valid = 1'b0;
    el = 100 * g; er = -100 * g;
    if (at) begin el = el >>> 2; er = er >>> 2; end
    check({req, " valid"}, int'(smp_valid_o), 1);
    check({req, " left"}, int'(smp_l_o), el);
    check({req, " right"}, int'(smp_r_o), er);
    @(negedge clk);
    check("R2 strobe single", int'(smp_valid_o), 0);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(smp_valid_o), 0);
    check("R1 left", int'(smp_l_o), 0);
    probe_at(cyc + 1, 0, 0, "R1 gain zero");
  endtask

  task automatic t_full_ramp;
    int e;
    speed = 2'd0;
    send_cmd(4'h2, e);
    probe_at(e + 1, 0, 0, "R4 start");
    probe_at(e + 5 * 16 + 1, 5, 0, "R5 step16");
    probe_at(e + 128 * 16 + 1, 128, 0, "R4 unity");
    probe_at(e + 140 * 16 + 1, 128, 0, "R4 hold");
  endtask

  task automatic t_attn;
    int e;
    send_cmd(4'h3, e);
    probe_at(e + 1, 128, 1, "R6 attn");
    send_cmd(4'h2, e);
    probe_at(e + 1, 128, 0, "R4 clears attn");
  endtask

  task automatic t_mute;
    int e;
    speed = 2'd2;
    send_cmd(4'h1, e);
    probe_at(e + 4 + 1, 127, 0, "R3 first step");
    probe_at(e + 64 * 4 + 1, 64, 0, "R5 step4");
    probe_at(e + 128 * 4 + 1, 0, 0, "R3 silent at 128");
    probe_at(e + 130 * 4 + 1, 0, 0, "R3 stays silent");
  endtask

  task automatic t_fade;
    int e;
    speed = 2'd3;
    send_cmd(4'b1010, e);
    probe_at(e + 32 * 2 + 1, 32, 0, "R7 up to 32");
    probe_at(e + 40 * 2 + 1, 32, 0, "R7 stop 32");
    send_cmd(4'b1110, e);
    probe_at(e + 64 * 2 + 1, 96, 0, "R7 up to 96");
    send_cmd(4'b1010, e);
    probe_at(e + 10 * 2 + 1, 86, 0, "R7 down");
    probe_at(e + 70 * 2 + 1, 32, 0, "R7 down stop");
  endtask

  task automatic t_midramp;
    int e, t;
    speed = 2'd1;
    send_cmd(4'h2, e);
    t = e + 20 * 8 + 1;
    probe_at(t, 52, 0, "R8 before turn");
    send_cmd(4'h1, e);
    probe_at(e + 1, 52, 0, "R8 no jump");
    probe_at(e + 5 * 8 + 1, 47, 0, "R8 reversed");
  endtask

  task automatic t_ignore;
    int e, d;
    send_cmd(4'h2, e);
    probe_at(e + 130 * 8 + 1, 128, 0, "R9 setup");
    send_cmd(4'h0, d);
    send_cmd(4'h5, d);
    send_cmd(4'h7, d);
    probe_at(cyc + 40, 128, 0, "R9 ignored");
    send_cmd(4'h1, e);
    send_cmd(4'h4, d);
    probe_at(e + 3 * 8 + 1, 125, 0, "R9 no restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_ramp();
    t_attn();
    t_mute();
    t_fade();
    t_midramp();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule